// File: doc/BRIEF.md
# Bus Direction Traffic-Period Arbiter

This block chooses whether a shared bidirectional DMA bus serves a read or a write next. Each turnaround costs bus cycles, so after an access the block favours further accesses in the same direction for a programmable number of clock cycles. When that window runs out, it favours the opposite direction. The remaining window is exposed as a count that can be read back. The requestors report pending reads and writes. The bus reports each access it takes, with its direction, and any stall cycles. A configuration write sets the window length.

One instance is placed on each bus. The block outputs a registered preferred direction and a per-cycle pick. The pick is the direction the bus should serve given what is pending now. A window length of zero turns the preference off. In that mode, contention goes to the request that has waited longest.

Top module: `dta_arbiter`

## Requirements
- R1: After a synchronous reset, `count` equals parameter `RST_PERIOD`, `pref_dir` is 0 (read) and `pick_vld` is 0. Direction encoding everywhere is 0 = read, 1 = write.
- R2: A cycle with `cfg_we` high stores `cfg_period` as the window length and loads it into `count` at the next edge, whatever else happens in that cycle.
- R3: A taken access (`take` high) whose `take_dir` differs from the direction of the previous taken access reloads `count` from the window length.
- R4: A cycle with no pending request and no taken access (bus idle) reloads `count` from the window length.
- R5: During `stall`, when no configuration write, turnaround or idle condition applies, `count` keeps its value.
- R6: In every other cycle `count` drops by one per clock while nonzero, and stays at 0 once there.
- R7: A same-direction taken access while `count` is 0 (and no stall) reloads `count` from the window length, starting a new burst.
- R8: With a nonzero window length, `pref_dir` equals the direction of the last taken access while `count` is nonzero and the opposite direction when `count` is 0. It is registered and changes together with `count`.
- R9: When exactly one direction is pending, `pick_vld` is 1 and `pick_dir` is that direction, whatever the preference.
- R10: When both directions are pending and the window length is nonzero, `pick_dir` equals `pref_dir`.
- R11: With a window length of 0, contention goes to the direction that has been pending longer. If both became pending in the same cycle, it goes to the opposite of the last taken direction. `pref_dir` shows this choice one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_pend | input | 1 | A read is waiting for the bus |
| wr_pend | input | 1 | A write is waiting for the bus |
| take | input | 1 | The bus performs an access this cycle |
| take_dir | input | 1 | Direction of that access (0 read, 1 write) |
| stall | input | 1 | DMA stall cycle; the window does not advance |
| cfg_we | input | 1 | Write strobe for the window length |
| cfg_period | input | PW | New window length in cycles |
| pick_vld | output | 1 | Some request is pending |
| pick_dir | output | 1 | Direction to serve this cycle |
| pref_dir | output | 1 | Registered preferred direction |
| count | output | PW | Remaining cycles in the current window |

## Verification
The bench builds the block with a 4-bit window and a reset length of 5. It programs every window length from 0 to 15 in turn. For each length, directed phases cover a full countdown to zero and the preference flip there, a burst restart at zero, stalls, idle cycles and simultaneous contention. A long pseudo-random phase then runs against an arithmetic model of the requirements. Length 0 brings the oldest-request mode within reach. Lengths 1 and 15 bring the one-cycle window and the largest counter value within reach.

// File: rtl/dta_pkg.sv
package dta_pkg;
  localparam logic DIR_RD = 1'b0;
  localparam logic DIR_WR = 1'b1;

  // Cause of the next count value, in priority order
  typedef enum logic [2:0] {
    EV_CFG   = 3'd0,
    EV_TURN  = 3'd1,
    EV_IDLE  = 3'd2,
    EV_STALL = 3'd3,
    EV_BURST = 3'd4,
    EV_DEC   = 3'd5,
    EV_HOLD  = 3'd6
  } cnt_ev_t;
endpackage

// File: rtl/dta_event.sv
module dta_event
  import dta_pkg::*;
(
  input  logic    cfg_we,
  input  logic    take,
  input  logic    take_dir,
  input  logic    last_dir,
  input  logic    rd_pend,
  input  logic    wr_pend,
  input  logic    stall,
  input  logic    cnt_zero,
  output cnt_ev_t ev
);
  logic turn, idle;

  assign turn = take && (take_dir != last_dir);
  assign idle = !rd_pend && !wr_pend && !take;

  always_comb begin
    if (cfg_we)               ev = EV_CFG;
    else if (turn)            ev = EV_TURN;
    else if (idle)            ev = EV_IDLE;
    else if (stall)           ev = EV_STALL;
    else if (take && cnt_zero) ev = EV_BURST;
    else if (!cnt_zero)       ev = EV_DEC;
    else                      ev = EV_HOLD;
  end
endmodule

// File: rtl/dta_counter.sv
module dta_counter
  import dta_pkg::*;
#(
  parameter int unsigned PW         = 4,
  parameter int unsigned RST_PERIOD = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  cnt_ev_t       ev,
  input  logic [PW-1:0] cfg_period,
  output logic [PW-1:0] per_q,
  output logic [PW-1:0] per_n,
  output logic [PW-1:0] cnt_q,
  output logic [PW-1:0] cnt_n
);
  localparam logic [PW-1:0] RST_VAL = PW'(RST_PERIOD);

  assign per_n = (ev == EV_CFG) ? cfg_period : per_q;

  always_comb begin
    case (ev)
      EV_CFG:                    cnt_n = cfg_period;
      EV_TURN, EV_IDLE, EV_BURST: cnt_n = per_q;
      EV_DEC:                    cnt_n = cnt_q - 1'b1;
      default:                   cnt_n = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      per_q <= RST_VAL;
      cnt_q <= RST_VAL;
    end else begin
      per_q <= per_n;
      cnt_q <= cnt_n;
    end
  end
endmodule

// File: rtl/dta_oldest.sv
module dta_oldest
  import dta_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rd_pend,
  input  logic wr_pend,
  input  logic last_dir,
  output logic old_dir
);
  logic prev_rd, prev_wr, hold_q;

  always_comb begin
    if (rd_pend && !wr_pend)       old_dir = DIR_RD;
    else if (wr_pend && !rd_pend)  old_dir = DIR_WR;
    else if (!rd_pend && !wr_pend) old_dir = hold_q;
    else if (prev_rd && prev_wr)   old_dir = hold_q;
    else if (prev_rd)              old_dir = DIR_RD;
    else if (prev_wr)              old_dir = DIR_WR;
    else                           old_dir = !last_dir;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_rd <= 1'b0;
      prev_wr <= 1'b0;
      hold_q  <= DIR_RD;
    end else begin
      prev_rd <= rd_pend;
      prev_wr <= wr_pend;
      hold_q  <= old_dir;
    end
  end
endmodule

// File: rtl/dta_arbiter.sv
module dta_arbiter
  import dta_pkg::*;
#(
  parameter int unsigned PW         = 4,
  parameter int unsigned RST_PERIOD = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_pend,
  input  logic          wr_pend,
  input  logic          take,
  input  logic          take_dir,
  input  logic          stall,
  input  logic          cfg_we,
  input  logic [PW-1:0] cfg_period,
  output logic          pick_vld,
  output logic          pick_dir,
  output logic          pref_dir,
  output logic [PW-1:0] count
);
  cnt_ev_t       ev;
  logic [PW-1:0] period_q, period_n, cnt_n;
  logic          last_q, last_n, old_dir, pref_n;

  dta_event u_ev (
    .cfg_we(cfg_we), .take(take), .take_dir(take_dir), .last_dir(last_q),
    .rd_pend(rd_pend), .wr_pend(wr_pend), .stall(stall),
    .cnt_zero(count == '0), .ev(ev)
  );

  dta_counter #(.PW(PW), .RST_PERIOD(RST_PERIOD)) u_cnt (
    .clk(clk), .rst(rst), .ev(ev), .cfg_period(cfg_period),
    .per_q(period_q), .per_n(period_n), .cnt_q(count), .cnt_n(cnt_n)
  );

  dta_oldest u_old (
    .clk(clk), .rst(rst), .rd_pend(rd_pend), .wr_pend(wr_pend),
    .last_dir(last_q), .old_dir(old_dir)
  );

  assign last_n = take ? take_dir : last_q;

  always_comb begin
    if (period_n == '0)      pref_n = old_dir;
    else if (cnt_n != '0)    pref_n = last_n;
    else                     pref_n = !last_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q   <= DIR_RD;
      pref_dir <= DIR_RD;
    end else begin
      last_q   <= last_n;
      pref_dir <= pref_n;
    end
  end

  assign pick_vld = rd_pend || wr_pend;
  assign pick_dir = (rd_pend && wr_pend) ? ((period_q == '0) ? old_dir : pref_dir)
                                         : wr_pend;
endmodule

// File: rtl/dta_arbiter_chk.sv
module dta_arbiter_chk #(
  parameter int unsigned PW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          rd_pend,
  input logic          wr_pend,
  input logic          take,
  input logic          stall,
  input logic          cfg_we,
  input logic [PW-1:0] cfg_period,
  input logic          pick_vld,
  input logic          pick_dir,
  input logic [PW-1:0] count,
  input logic [PW-1:0] period_q
);
  a_r2_cfg_load: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> count == $past(cfg_period));

  a_r4_idle_reload: assert property (@(posedge clk) disable iff (rst)
    (!cfg_we && !rd_pend && !wr_pend && !take) |=> count == $past(period_q));

  a_r5_stall_hold: assert property (@(posedge clk) disable iff (rst)
    (stall && !cfg_we && !take && (rd_pend || wr_pend)) |=> count == $past(count));

  a_r6_decrement: assert property (@(posedge clk) disable iff (rst)
    (!stall && !cfg_we && !take && (rd_pend || wr_pend) && count != '0)
    |=> count == PW'($past(count) - 1'b1));

  a_r7_burst_restart: assert property (@(posedge clk) disable iff (rst)
    (take && !stall && !cfg_we && count == '0) |=> count == $past(period_q));

  a_r9_single_pending: assert property (@(posedge clk) disable iff (rst)
    (rd_pend ^ wr_pend) |-> (pick_vld && pick_dir == wr_pend));
endmodule

bind dta_arbiter dta_arbiter_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst(rst), .rd_pend(rd_pend), .wr_pend(wr_pend), .take(take),
  .stall(stall), .cfg_we(cfg_we), .cfg_period(cfg_period), .pick_vld(pick_vld),
  .pick_dir(pick_dir), .count(count), .period_q(period_q)
);

// File: tb/sim_dta_arbiter.sv
module sim_dta_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 4;
  localparam int RST_PERIOD = 5;

  logic clk = 1'b0, rst = 1'b1;
  logic rd_pend = 0, wr_pend = 0, take = 0, take_dir = 0, stall = 0, cfg_we = 0;
  logic [PW-1:0] cfg_period = '0;
  logic pick_vld, pick_dir, pref_dir;
  logic [PW-1:0] count;

  int errors = 0, checks = 0;
  bit done = 0;

  // bench model state
  int m_cnt, m_per;
  bit m_last, m_hold, m_prd, m_pwr, m_pref;
  string m_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  dta_arbiter #(.PW(PW), .RST_PERIOD(RST_PERIOD)) u0 (
    .clk(clk), .rst(rst), .rd_pend(rd_pend), .wr_pend(wr_pend), .take(take),
    .take_dir(take_dir), .stall(stall), .cfg_we(cfg_we), .cfg_period(cfg_period),
    .pick_vld(pick_vld), .pick_dir(pick_dir), .pref_dir(pref_dir), .count(count)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit model_old();
    if (rd_pend && !wr_pend) return 1'b0;
    if (wr_pend && !rd_pend) return 1'b1;
    if (!rd_pend && !wr_pend) return m_hold;
    if (m_prd && m_pwr) return m_hold;
    if (m_prd) return 1'b0;
    if (m_pwr) return 1'b1;
    return !m_last;
  endfunction

  // registered outputs, checked at the falling edge before new inputs
  task automatic check_regs();
    chk(m_tag, int'(count), m_cnt);
    chk(m_per == 0 ? "R11 pref" : "R8 pref", int'(pref_dir), int'(m_pref));
  endtask

  task automatic step(input bit r, input bit w, input bit tk, input bit td,
                      input bit st, input bit we, input int pv);
    bit o, ln;
    int nc;
    @(negedge clk);
    check_regs();
    rd_pend = r; wr_pend = w; take = tk; take_dir = td; stall = st;
    cfg_we = we; cfg_period = PW'(pv);
    #1;
    o = model_old();
    chk("R9 vld", int'(pick_vld), int'(r | w));
    if (r ^ w) chk("R9 dir", int'(pick_dir), int'(w));
    else if (r && w) chk(m_per == 0 ? "R11 pick" : "R10 pick", int'(pick_dir),
                         int'(m_per == 0 ? o : m_pref));
    @(posedge clk);
    // model update from the requirements
    if (we)                     begin nc = pv;    m_tag = "R2";  end
    else if (tk && td != m_last) begin nc = m_per; m_tag = "R3"; end
    else if (!r && !w && !tk)   begin nc = m_per; m_tag = "R4";  end
    else if (st)                begin nc = m_cnt; m_tag = "R5";  end
    else if (tk && m_cnt == 0)  begin nc = m_per; m_tag = "R7";  end
    else if (m_cnt != 0)        begin nc = m_cnt - 1; m_tag = "R6"; end
    else                        begin nc = 0;     m_tag = "R6";  end
    if (we) m_per = pv;
    ln = tk ? td : m_last;
    m_cnt = nc;
    m_last = ln;
    m_hold = o;
    m_prd = r; m_pwr = w;
    m_pref = (m_per == 0) ? o : ((m_cnt != 0) ? ln : !ln);
  endtask

  initial begin
    m_cnt = RST_PERIOD; m_per = RST_PERIOD; m_last = 0; m_hold = 0;
    m_prd = 0; m_pwr = 0; m_pref = 0; m_tag = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    chk("R1 count", int'(count), RST_PERIOD);
    chk("R1 pref", int'(pref_dir), 0);
    chk("R1 vld", int'(pick_vld), 0);
    for (int p = 0; p < 16; p++) begin
      step(1, 0, 0, 0, 0, 1, p);                         // load period (R2)
      for (int k = 0; k < p + 2; k++) step(1, 0, 0, 0, 0, 0, 0); // countdown, flip (R6, R8)
      step(1, 1, 0, 0, 0, 0, 0);                         // contention at zero (R10)
      step(1, 0, 1, 0, 0, 0, 0);                         // same-dir take at zero (R7)
      for (int k = 0; k < 3; k++) step(1, 1, 0, 0, 1, 0, 0); // stall (R5)
      step(0, 1, 1, 1, 0, 0, 0);                         // turnaround (R3)
      step(0, 0, 0, 0, 0, 0, 0);                         // idle (R4)
      step(1, 1, 0, 0, 0, 0, 0);                         // simultaneous arrival (R11)
      step(1, 1, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0, 0);
      for (int k = 0; k < 400; k++) begin
        bit r, w, tk, td, st, we;
        int pv;
        r  = ($urandom % 3) != 0;
        w  = ($urandom % 3) != 0;
        tk = (r | w) && (($urandom % 2) == 0);
        td = (r && w) ? (($urandom % 4) != 0 ? pick_dir_pred(r, w) : $urandom % 2)
                      : w;
        st = ($urandom % 5) == 0;
        we = ($urandom % 60) == 0;
        pv = (($urandom % 2) == 0) ? p : int'($urandom % 16);
        step(r, w, tk, td, st, we, pv);
      end
    end
    @(negedge clk);
    check_regs();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  function automatic bit pick_dir_pred(input bit r, input bit w);
    if (r ^ w) return w;
    if (m_per == 0) return m_hold;
    return m_pref;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule